// File: doc/BRIEF.md
# Replicated Multiport Register File

This block is the integer register file of a processor core whose execution units are split into two clusters. Internally it keeps two full, identical copies of every architectural register. Each copy feeds the read ports of one cluster, so a copy needs only half of the total read ports. The rest of the core still sees one logical file with two write ports and four read ports. Every write, after port arbitration, goes to both copies on the same clock edge. The copies therefore never diverge, and software cannot tell this file from a single file with four read ports and two write ports.

Read ports 0 and 1 are served by copy A, and read ports 2 and 3 by copy B. Reads are combinational and show the contents as they were before the current edge. A write becomes visible on every read port in the cycle after it is accepted. All ports are plain, with no back-pressure: a write port with its enable high is always accepted on that edge. The read ports have no handshake. A status pin reports whether the two copies disagree at any register. In a correct design that pin stays low.

Top module: `rfrep_top`

## Requirements
- R1: While reset is low and after it is released, every register in both copies reads as zero on every read port until it is written.
- R2: A write on an enabled write port stores its data at its register index (0 to NREGS-1) on the rising clock edge. The new value is readable on all read ports from the next cycle on.
- R3: Two enabled write ports aimed at different registers in the same cycle both take effect on that edge.
- R4: When both write ports are enabled with the same register index in one cycle, the data of write port 1 (the higher port index) is stored in both copies.
- R5: Reads are combinational with no bypass. A read of a register that is being written in the same cycle returns the value it held before that edge.
- R6: Read ports 0 and 1 are served by copy A and read ports 2 and 3 by copy B. Any two read ports given the same index return the same value in every cycle.
- R7: A write port with its enable low has no effect, whatever its index and data inputs carry.
- R8: The copies_differ_o output is 1 exactly when the two copies hold different contents at some register. In operation without faults it is 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes take effect on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears both copies |
| wr_en_i | input | NWR | Per-port write enable; bit p belongs to write port p |
| wr_addr_i | input | NWR x AW | Register index of each write port |
| wr_data_i | input | NWR x WIDTH | Data of each write port |
| rd_addr_i | input | NRD x AW | Register index of each read port; lower half to copy A, upper half to copy B |
| rd_data_o | output | NRD x WIDTH | Combinational read data of each read port |
| copies_differ_o | output | 1 | High when the copies disagree at any register |

## Verification
Two things can fall in the same cycle. Both write ports can name one register, and a read port can address a register that is being written on that edge. The bench provokes both at once. For every register index it drives the two write ports with the same index and different data, and points all four read ports at that index. Before the edge, each read must still return the older value taken from the bench's own model. After the edge, all four ports, across both copies, must return the data of write port 1.

// File: rtl/rfrep_pkg.sv
package rfrep_pkg;

  // Width of an index able to select one of n items (at least 1 bit).
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Number of copies the file is replicated into.
  localparam int NCOPIES = 2;

endpackage

// File: rtl/rfrep_wsel.sv
// Resolves the write ports into one enable and one data word per register.
// A higher port index overrides a lower one on the same register.
module rfrep_wsel #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  parameter int NWR   = 2,
  parameter int AW    = 5
) (
  input  logic [NWR-1:0]                wr_en_i,
  input  logic [NWR-1:0][AW-1:0]        wr_addr_i,
  input  logic [NWR-1:0][WIDTH-1:0]     wr_data_i,
  output logic [NREGS-1:0]              reg_we_o,
  output logic [NREGS-1:0][WIDTH-1:0]   reg_wd_o
);

  always_comb begin
    for (int r = 0; r < NREGS; r++) begin
      reg_we_o[r] = 1'b0;
      reg_wd_o[r] = '0;
      // Ascending scan: the last matching port (highest index) wins.
      for (int p = 0; p < NWR; p++) begin
        if (wr_en_i[p] && (int'(wr_addr_i[p]) == r)) begin
          reg_we_o[r] = 1'b1;
          reg_wd_o[r] = wr_data_i[p];
        end
      end
    end
  end

endmodule

// File: rtl/rfrep_copy.sv
// One full copy of the architectural registers with its own read ports.
module rfrep_copy #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  parameter int NRP   = 2,
  parameter int AW    = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NREGS-1:0]              reg_we_i,
  input  logic [NREGS-1:0][WIDTH-1:0]   reg_wd_i,
  input  logic [NRP-1:0][AW-1:0]        rd_addr_i,
  output logic [NRP-1:0][WIDTH-1:0]     rd_data_o,
  output logic [NREGS-1:0][WIDTH-1:0]   snap_o
);

  logic [NREGS-1:0][WIDTH-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int r = 0; r < NREGS; r++) begin
        if (reg_we_i[r]) mem_q[r] <= reg_wd_i[r];
      end
    end
  end

  // Combinational read of pre-edge contents; out-of-range indices read zero.
  always_comb begin
    for (int k = 0; k < NRP; k++) begin
      rd_data_o[k] = '0;
      if (int'(rd_addr_i[k]) < NREGS) rd_data_o[k] = mem_q[rd_addr_i[k]];
    end
  end

  assign snap_o = mem_q;

  for (genvar r = 0; r < NREGS; r++) begin : g_chk
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we_i[r] |=> (mem_q[r] == $past(reg_wd_i[r]))); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_we_i[r] && !$isunknown(mem_q[r])) |=> $stable(mem_q[r])); // R7
  end

endmodule

// File: rtl/rfrep_cmp.sv
// Register-by-register comparison of the two copies.
module rfrep_cmp #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32
) (
  input  logic [NREGS-1:0][WIDTH-1:0] snap_a_i,
  input  logic [NREGS-1:0][WIDTH-1:0] snap_b_i,
  output logic                        differ_o
);

  logic [NREGS-1:0] ne;

  for (genvar r = 0; r < NREGS; r++) begin : g_ne
    assign ne[r] = (snap_a_i[r] != snap_b_i[r]);
  end

  assign differ_o = |ne;

endmodule

// File: rtl/rfrep_top.sv
// Logical 4-read / 2-write register file built from two synchronized copies.
module rfrep_top
  import rfrep_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  parameter int NWR   = 2,
  parameter int NRD   = 4,
  localparam int AW   = idx_w(NREGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NWR-1:0]            wr_en_i,
  input  logic [NWR-1:0][AW-1:0]    wr_addr_i,
  input  logic [NWR-1:0][WIDTH-1:0] wr_data_i,
  input  logic [NRD-1:0][AW-1:0]    rd_addr_i,
  output logic [NRD-1:0][WIDTH-1:0] rd_data_o,
  output logic                      copies_differ_o
);

  localparam int NRP = NRD / NCOPIES;

  logic [NREGS-1:0]                          reg_we;
  logic [NREGS-1:0][WIDTH-1:0]               reg_wd;
  logic [NCOPIES-1:0][NREGS-1:0][WIDTH-1:0]  snap;

  rfrep_wsel #(
    .NREGS (NREGS), .WIDTH (WIDTH), .NWR (NWR), .AW (AW)
  ) i_wsel (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .reg_we_o  (reg_we),
    .reg_wd_o  (reg_wd)
  );

  // Every copy receives the same resolved write; each serves its own read slice.
  for (genvar c = 0; c < NCOPIES; c++) begin : g_copy
    rfrep_copy #(
      .NREGS (NREGS), .WIDTH (WIDTH), .NRP (NRP), .AW (AW)
    ) i_copy (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we_i  (reg_we),
      .reg_wd_i  (reg_wd),
      .rd_addr_i (rd_addr_i[c*NRP +: NRP]),
      .rd_data_o (rd_data_o[c*NRP +: NRP]),
      .snap_o    (snap[c])
    );
  end

  rfrep_cmp #(
    .NREGS (NREGS), .WIDTH (WIDTH)
  ) i_cmp (
    .snap_a_i (snap[0]),
    .snap_b_i (snap[1]),
    .differ_o (copies_differ_o)
  );

  AST_COPIES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    !copies_differ_o); // R8

  AST_CROSS_COPY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i[0] == rd_addr_i[NRP]) |-> (rd_data_o[0] == rd_data_o[NRP])); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (snap[0][0] == '0 && snap[1][NREGS-1] == '0)); // R1

  if (NWR >= 2) begin : g_prio
    AST_HIGH_PORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i[0] && wr_en_i[1] && wr_addr_i[0] == wr_addr_i[1]
       && int'(wr_addr_i[1]) < NREGS)
      |=> (snap[1][$past(wr_addr_i[1])] == $past(wr_data_i[1]))); // R4
  end

endmodule

// File: tb/test_rfrep_top.sv
`timescale 1ns/1ps
module test_rfrep_top;

  localparam int NREGS = 32;
  localparam int WIDTH = 32;
  localparam int AW    = 5;

  logic                      clk = 1'b0;
  logic                      rst_n;
  logic [1:0]                wr_en;
  logic [1:0][AW-1:0]        wr_addr;
  logic [1:0][WIDTH-1:0]     wr_data;
  logic [3:0][AW-1:0]        rd_addr;
  logic [3:0][WIDTH-1:0]     rd_data;
  logic                      differ;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [WIDTH-1:0] refm [NREGS];
  logic [31:0] seed = 32'h1234_5679;

  always #2 clk = ~clk;  // 250 MHz

  rfrep_top i_rfrep_top (
    .clk (clk), .rst_n (rst_n),
    .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
    .rd_addr_i (rd_addr), .rd_data_o (rd_data),
    .copies_differ_o (differ)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [31:0] pat(input int r);
    return 32'hA500_0000 ^ (32'(r) * 32'h0101_0101) ^ 32'(r << 3);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, check reads (pre-edge contents),
  // clock, then update the model (port 1 applied last so it overrides).
  task automatic step(input string tag, input logic [1:0] en,
                      input logic [AW-1:0] a0, input logic [WIDTH-1:0] d0,
                      input logic [AW-1:0] a1, input logic [WIDTH-1:0] d1,
                      input logic [AW-1:0] r0, input logic [AW-1:0] r1,
                      input logic [AW-1:0] r2, input logic [AW-1:0] r3);
    wr_en = en; wr_addr[0] = a0; wr_data[0] = d0; wr_addr[1] = a1; wr_data[1] = d1;
    rd_addr[0] = r0; rd_addr[1] = r1; rd_addr[2] = r2; rd_addr[3] = r3;
    #1;
    for (int k = 0; k < 4; k++) check(tag, rd_data[k], refm[rd_addr[k]]);
    check("R8", {31'd0, differ}, 32'd0);
    @(posedge clk);
    if (en[0]) refm[a0] = d0;
    if (en[1]) refm[a1] = d1;
    @(negedge clk);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < NREGS; i++)
      step(tag, 2'b00, '0, '0, '0, '0, AW'(i), AW'(i + 8), AW'(i + 16), AW'(i + 24));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREGS; r++) refm[r] = '0;
    rst_n = 1'b0; wr_en = '0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    // R1: contents are zero during reset
    #1 for (int k = 0; k < 4; k++) check("R1", rd_data[k], 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    sweep("R1");

    // R3: two ports to different registers in one cycle
    for (int i = 0; i < NREGS / 2; i++)
      step("R3", 2'b11, AW'(2 * i), pat(2 * i), AW'(2 * i + 1), pat(2 * i + 1),
           AW'(i), AW'(i + 1), AW'(i + 2), AW'(i + 3));
    sweep("R2");
    // R6: each register read through every port, both copies
    sweep("R6");

    // R4 + R5: same-register collision while all ports read that register
    for (int r = 0; r < NREGS; r++)
      step("R5", 2'b11, AW'(r), ~pat(r), AW'(r), pat(r) ^ 32'h5A5A_5A5A,
           AW'(r), AW'(r), AW'(r), AW'(r));
    for (int r = 0; r < NREGS; r++) begin
      step("R4", 2'b00, '0, '0, '0, '0, AW'(r), AW'(r), AW'(r), AW'(r));
      check("R4", rd_data[2], pat(r) ^ 32'h5A5A_5A5A);
    end

    // R7: disabled ports carry junk and must change nothing
    for (int i = 0; i < NREGS; i++) begin
      seed = nxt(seed);
      step("R7", 2'b00, seed[4:0], seed, seed[9:5], ~seed,
           seed[4:0], seed[9:5], seed[4:0], seed[9:5]);
    end
    sweep("R7");

    // Mixed traffic, one port at a time and both, checked against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] s1, s2;
      seed = nxt(seed); s1 = seed;
      seed = nxt(seed); s2 = seed;
      step("R6", s1[1:0], s1[6:2], s2, s1[11:7], ~s2 ^ s1,
           s1[16:12], s1[21:17], s1[26:22], s1[31:27]);
    end
    sweep("R2");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule